// File: doc/BRIEF.md
# Bus Data-Phase Progress Tracker

This block follows the progress of a data phase on a parallel peripheral bus. Software loads a 24-bit remaining-byte count one byte at a time through a small register write port. Each time the bus side confirms that a transfer actually completed, the count steps down. At the same moment a 32-bit shadow address, which software cannot write, steps up by the same amount. The step is one byte in narrow mode and two bytes in wide mode. The shadow address therefore always marks the last byte that really crossed the bus, even when a host-side address has already run ahead of it.

Two sticky status bits record events. The done bit is set when a completion step lands the count exactly on zero. The wrap bit is set when a step borrows past zero. Software clears each bit by writing a one to its position in a clear register. A separate enable register selects which status bits may drive the interrupt request. A dedicated clear-count input zeroes the count in one cycle.

Top module: `xfer_progress`

## Requirements
- R1: A write with selector 0, 1 or 2 replaces bits 7:0, 15:8 or 23:16 of the count, respectively. The other bytes of the count are left unchanged.
- R2: A completion strobe reduces the count by 1 when wide mode is low and by 2 when wide mode is high. The count changes in the cycle after the strobe, modulo 2^24.
- R3: The shadow address starts at zero. It grows by exactly the amount the count drops, and only in cycles where the count is decremented.
- R4: In a cycle with a count byte write or a clear-count request, a completion strobe is ignored. Neither the count nor the shadow address moves because of it.
- R5: The clear-count input sets the count to zero. It takes priority over a count byte write in the same cycle.
- R6: Status bit 0 (done) is set only when a completion strobe takes the count to exactly zero. Writing a zero count, or using clear-count, does not set it.
- R7: Status bit 1 (wrap) is set when a completion strobe finds the count below the step size. In that case the count rolls over, and done is not set by that strobe.
- R8: A write with selector 3 clears each status bit whose data bit is one (bit 0 for done, bit 1 for wrap). A bit that is being set in the same cycle stays set.
- R9: A write with selector 4 loads the interrupt enables (bit 0 for done, bit 1 for wrap). The interrupt request is high exactly when some status bit is set and its enable is set.
- R10: After reset the count, the shadow address, the status, the enables and the interrupt request are all zero.
- R11: Writes with selectors 5, 6 and 7 change neither the count, the status nor the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 8 | Register write data |
| zero_cnt | input | 1 | Clear-count command |
| beat_done | input | 1 | Confirmed transfer completion strobe |
| wide_mode | input | 1 | High selects a two-byte step |
| remain_cnt | output | 24 | Remaining byte count |
| shadow_addr | output | 32 | Address of the last byte completed |
| status | output | 2 | Sticky status, bit 1 wrap, bit 0 done |
| irq | output | 1 | Interrupt request |

## Verification
The count is driven with narrow strobes and with wide strobes. Comparing the count and shadow address afterwards shows that both step sizes are applied and that both registers move together.

Approaches to zero are tried from two directions. Stepping from one to zero and from two to zero must set done. Stepping from zero with a narrow strobe, and from one with a wide strobe, must set only wrap. This separates an exact landing from a borrow.

Strobes are also presented alongside byte writes, clear-count and status-clear writes. These cycles show which action wins. Writes of zero counts and writes to unused selectors are checked to leave the status and the interrupt untouched.

// File: rtl/xfer_progress_pkg.sv
package xfer_progress_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CNT_B0 = 3'd0,
        SEL_CNT_B1 = 3'd1,
        SEL_CNT_B2 = 3'd2,
        SEL_STCLR  = 3'd3,
        SEL_IRQEN  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic wrap;
        logic done;
    } stat_t;

    typedef struct packed {
        logic       en;
        logic [1:0] amount;
    } step_t;

    function automatic logic [1:0] step_size(input logic wide);
        return wide ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/xfer_count.sv
module xfer_count
    import xfer_progress_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [7:0]           wr_data,
    input  logic                 zero_cnt,
    input  logic                 beat_done,
    input  logic                 wide,
    output logic [CNT_W-1:0]     cnt,
    output step_t                adv,
    output logic                 hit_zero,
    output logic                 borrow_ev
);
    localparam int NBYTE = CNT_W / 8;

    logic [NBYTE-1:0] byte_we;
    logic [CNT_W-1:0] load_val;
    logic             load;
    logic [CNT_W:0]   diff;

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        assign byte_we[i] = wr_en && (wr_sel == SEL_W'(i));
        assign load_val[8*i +: 8] = byte_we[i] ? wr_data : cnt[8*i +: 8];
    end

    assign load = |byte_we;

    always_comb begin
        adv.en     = beat_done && !load && !zero_cnt;
        adv.amount = step_size(wide);
        diff       = {1'b0, cnt} - {{(CNT_W-1){1'b0}}, adv.amount};
    end

    assign borrow_ev = adv.en && diff[CNT_W];
    assign hit_zero  = adv.en && !diff[CNT_W] && (diff[CNT_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (zero_cnt) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (adv.en) begin
            cnt <= diff[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/xfer_shadow.sv
module xfer_shadow
    import xfer_progress_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             adv,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (adv.en) begin
            addr <= addr + ADDR_W'(adv.amount);
        end
    end
endmodule

// File: rtl/xfer_status.sv
module xfer_status
    import xfer_progress_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             set_done,
    input  logic             set_wrap,
    output stat_t            stat,
    output logic             irq
);
    stat_t en_q;
    stat_t clr;
    stat_t set;

    always_comb begin
        clr      = (wr_en && wr_sel == SEL_STCLR) ? stat_t'(wr_data[1:0]) : '0;
        set.done = set_done;
        set.wrap = set_wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en_q <= '0;
        end else begin
            stat <= (stat & ~clr) | set;
            if (wr_en && wr_sel == SEL_IRQEN) begin
                en_q <= stat_t'(wr_data[1:0]);
            end
        end
    end

    assign irq = |(stat & en_q);
endmodule

// File: rtl/xfer_progress.sv
module xfer_progress
    import xfer_progress_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              zero_cnt,
    input  logic              beat_done,
    input  logic              wide_mode,
    output logic [CNT_W-1:0]  remain_cnt,
    output logic [ADDR_W-1:0] shadow_addr,
    output logic [1:0]        status,
    output logic              irq
);
    step_t adv;
    logic  hit_zero;
    logic  borrow_ev;
    stat_t stat;

    xfer_count #(.CNT_W(CNT_W)) i_count (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_we),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .zero_cnt  (zero_cnt),
        .beat_done (beat_done),
        .wide      (wide_mode),
        .cnt       (remain_cnt),
        .adv       (adv),
        .hit_zero  (hit_zero),
        .borrow_ev (borrow_ev)
    );

    xfer_shadow #(.ADDR_W(ADDR_W)) i_shadow (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .addr (shadow_addr)
    );

    xfer_status i_status (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata),
        .set_done (hit_zero),
        .set_wrap (borrow_ev),
        .stat     (stat),
        .irq      (irq)
    );

    assign status = stat;
endmodule

// File: rtl/xfer_progress_chk.sv
module xfer_progress_chk #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic [7:0]        reg_wdata,
    input logic              zero_cnt,
    input logic              beat_done,
    input logic              wide_mode,
    input logic [CNT_W-1:0]  remain_cnt,
    input logic [ADDR_W-1:0] shadow_addr,
    input logic [1:0]        status,
    input logic              irq
);
    logic cnt_wr;
    assign cnt_wr = reg_we && (reg_sel <= 3'd2);

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (beat_done && (cnt_wr || zero_cnt)) |=> $stable(shadow_addr)) else $error("AST_LOAD_WINS"); // R4

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        zero_cnt |=> (remain_cnt == '0)) else $error("AST_CLR_ZERO"); // R5

    AST_SHADOW_STEP: assert property (@(posedge clk) disable iff (rst)
        (beat_done && !cnt_wr && !zero_cnt) |=>
        (shadow_addr == $past(shadow_addr) + ($past(wide_mode) ? 32'd2 : 32'd1))) else $error("AST_SHADOW_STEP"); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!beat_done && !cnt_wr && !zero_cnt) |=> ($stable(remain_cnt) && $stable(shadow_addr))) else $error("AST_IDLE_HOLD"); // R2

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> (remain_cnt == '0)) else $error("AST_DONE_AT_ZERO"); // R6

    AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b00) |-> !irq) else $error("AST_NO_IRQ_IDLE"); // R9
endmodule

bind xfer_progress xfer_progress_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_xfer_progress_chk (.*);

// File: tb/test_xfer_progress.sv
module test_xfer_progress;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic        zero_cnt;
    logic        beat_done;
    logic        wide_mode;
    logic [23:0] remain_cnt;
    logic [31:0] shadow_addr;
    logic [1:0]  status;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_sh = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_progress i_xfer_progress (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_we = 0; reg_sel = 0; reg_wdata = 0;
        zero_cnt = 0; beat_done = 0; wide_mode = 0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic strobe(input logic wide);
        @(negedge clk);
        beat_done = 1; wide_mode = wide;
        @(negedge clk);
        idle_inputs();
        exp_sh += wide ? 2 : 1;
    endtask

    task automatic load(input logic [23:0] v);
        wr(3'd0, v[7:0]);
        wr(3'd1, v[15:8]);
        wr(3'd2, v[23:16]);
    endtask

    task automatic t_reset();
        chk("R10", "count", 32'(remain_cnt), 0);
        chk("R10", "shadow", shadow_addr, 0);
        chk("R10", "status", 32'(status), 0);
        chk("R10", "irq", 32'(irq), 0);
    endtask

    task automatic t_load();
        wr(3'd0, 8'h34);
        chk("R1", "low byte", 32'(remain_cnt), 32'h000034);
        wr(3'd1, 8'h12);
        wr(3'd2, 8'h56);
        chk("R1", "full count", 32'(remain_cnt), 32'h561234);
        wr(3'd1, 8'hAB);
        chk("R1", "mid byte only", 32'(remain_cnt), 32'h56AB34);
        chk("R1", "status after load", 32'(status), 0);
    endtask

    task automatic t_steps();
        load(24'h561234);
        repeat (3) strobe(1'b0);
        chk("R2", "narrow steps", 32'(remain_cnt), 32'h561231);
        chk("R3", "shadow narrow", shadow_addr, exp_sh);
        repeat (2) strobe(1'b1);
        chk("R2", "wide steps", 32'(remain_cnt), 32'h56122D);
        chk("R3", "shadow wide", shadow_addr, exp_sh);
    endtask

    task automatic t_done();
        load(24'h000000);
        chk("R6", "zero load no done", 32'(status), 0);
        wr(3'd0, 8'h03);
        strobe(1'b1);
        chk("R6", "before zero", 32'(status), 0);
        strobe(1'b0);
        chk("R6", "count zero", 32'(remain_cnt), 0);
        chk("R6", "done set", 32'(status), 32'b01);
        chk("R3", "shadow", shadow_addr, exp_sh);
    endtask

    task automatic t_wrap();
        strobe(1'b0);
        chk("R7", "narrow wrap count", 32'(remain_cnt), 32'hFFFFFF);
        chk("R7", "wrap status", 32'(status), 32'b11);
        wr(3'd3, 8'h01);
        chk("R8", "clear done", 32'(status), 32'b10);
        wr(3'd3, 8'h00);
        chk("R8", "zero write keeps", 32'(status), 32'b10);
        wr(3'd3, 8'h02);
        chk("R8", "clear wrap", 32'(status), 32'b00);
        load(24'h000001);
        strobe(1'b1);
        chk("R7", "wide wrap count", 32'(remain_cnt), 32'hFFFFFF);
        chk("R7", "wide wrap wrap only", 32'(status), 32'b10);
        wr(3'd3, 8'h03);
    endtask

    task automatic t_set_beats_clear();
        load(24'h000001);
        @(negedge clk);
        beat_done = 1; wide_mode = 0; reg_we = 1; reg_sel = 3'd3; reg_wdata = 8'h01;
        @(negedge clk);
        idle_inputs();
        exp_sh += 1;
        chk("R8", "set wins", 32'(status), 32'b01);
        chk("R3", "shadow", shadow_addr, exp_sh);
    endtask

    task automatic t_priority();
        @(negedge clk);
        beat_done = 1; reg_we = 1; reg_sel = 3'd0; reg_wdata = 8'h20;
        @(negedge clk);
        idle_inputs();
        chk("R4", "load beats strobe", 32'(remain_cnt), 32'h000020);
        chk("R4", "shadow held on load", shadow_addr, exp_sh);
        @(negedge clk);
        beat_done = 1; zero_cnt = 1;
        @(negedge clk);
        idle_inputs();
        chk("R4", "shadow held on clear", shadow_addr, exp_sh);
        chk("R5", "clear count", 32'(remain_cnt), 0);
        chk("R6", "status after clear", 32'(status), 32'b01);
        @(negedge clk);
        zero_cnt = 1; reg_we = 1; reg_sel = 3'd0; reg_wdata = 8'h55;
        @(negedge clk);
        idle_inputs();
        chk("R5", "clear beats write", 32'(remain_cnt), 0);
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h05);
        @(negedge clk);
        zero_cnt = 1;
        @(negedge clk);
        idle_inputs();
        chk("R6", "clear-count no done", 32'(status), 0);
    endtask

    task automatic t_irq();
        load(24'h000001);
        strobe(1'b0);
        chk("R9", "no enable no irq", 32'(irq), 0);
        wr(3'd4, 8'h02);
        chk("R9", "other enable no irq", 32'(irq), 0);
        wr(3'd4, 8'h01);
        chk("R9", "enabled irq", 32'(irq), 1);
        wr(3'd3, 8'h01);
        chk("R9", "cleared irq", 32'(irq), 0);
    endtask

    task automatic t_ignored();
        load(24'h000000);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        chk("R11", "count untouched", 32'(remain_cnt), 0);
        chk("R11", "status untouched", 32'(status), 0);
        strobe(1'b0);
        chk("R11", "wrap status", 32'(status), 32'b10);
        chk("R11", "enables untouched", 32'(irq), 0);
        chk("R3", "shadow final", shadow_addr, exp_sh);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_load();
        t_steps();
        t_done();
        t_wrap();
        t_set_beats_clear();
        t_priority();
        t_irq();
        t_ignored();
        done_flag = 1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule